// File: doc/BRIEF.md
# Serial Keyboard Receive Interface

This block takes scan codes that a keyboard microcontroller sends one bit at a time on a clock line and a data line, and turns each frame into a parallel byte. A frame is nine bits: a start bit followed by eight data bits. The byte is held for the host on an 8-bit read port, and a level interrupt tells the host that it is waiting.

Two control bits come from a port register that the host writes. The enable bit lets reception run or stops it. The clear bit blanks the read port, erases the held byte, drops the interrupt and re-arms the receiver. After each byte the receiver takes no more bits until the clear bit is pulsed. The block pushes back on the keyboard through an open-drain-style output: while that output is high, the board pulls the keyboard clock low. The keyboard must then wait before it sends more bits. This is the only back-pressure in the path. There is no valid/ready pair, because the byte leaves through a read port and an interrupt, not as a stream.

Top module: `kbd_serial_rx`

## Requirements
- R1: A frame is a start bit of value 1, then 8 data bits, least significant bit first. Each bit is taken on a falling edge of the keyboard clock after it has been synchronised. The byte is complete after the ninth falling edge.
- R2: `irq_o` goes high once a complete frame has been received. It stays high until `ctl_clear_i` is 1.
- R3: While `ctl_clear_i` is 0, `port_a_o` shows the last byte received, bit 0 being the first data bit.
- R4: While `ctl_clear_i` is 1, `port_a_o` is 0. The held byte is erased, so the port still reads 0 after the clear bit goes back to 0.
- R5: While `ctl_enable_i` is 0, no serial bit is accepted, and a frame that was partly received does not advance.
- R6: While `irq_o` is high, further serial bits are ignored and the held byte does not change.
- R7: Setting `ctl_clear_i` to 1 drops `irq_o` and empties the shift register, so a partial frame is thrown away. When `ctl_clear_i` returns to 0 with `ctl_enable_i` at 1, reception is armed again.
- R8: `kbd_clk_hold_o` is 1 while reception is disabled, while a byte is pending or while `ctl_clear_i` is 1. It is 0 when the receiver is armed.
- R9: A synchronous active-high `rst` empties the shift register, clears the held byte and drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| kbd_clk_i | input | 1 | Keyboard serial clock (asynchronous) |
| kbd_data_i | input | 1 | Keyboard serial data (asynchronous) |
| ctl_enable_i | input | 1 | 1 = reception enabled, 0 = inhibited |
| ctl_clear_i | input | 1 | 1 = blank port, erase byte, drop IRQ, re-arm |
| kbd_clk_hold_o | output | 1 | 1 = pull keyboard clock low (wait) |
| port_a_o | output | 8 | Received byte read port |
| irq_o | output | 1 | Keyboard interrupt request, level |

## Verification
The hardest state to reach from the ports is a partial frame that is later thrown away or frozen. The bench sends only a few bits of a frame and then pulses the clear bit, raises reset or drops the enable bit. After that it sends a full frame. That frame decodes correctly only if the leftover bits were discarded or kept exactly as they were. The other hard case is the locked receiver: a second frame is sent while the interrupt is pending, and the bench checks that the held byte did not move.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  parameter int KBD_BYTE_W = 8;

  typedef struct packed {
    logic clear;
    logic enable;
  } kbd_ctl_t;
endpackage

// File: rtl/kbd_rx_sync.sv
module kbd_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RESET_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/kbd_rx_shifter.sv
module kbd_rx_shifter #(
  parameter int BYTE_W = 8,
  localparam int FRAME_W = BYTE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              armed_i,
  input  logic              fall_i,
  input  logic              bit_i,
  output logic              done_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [FRAME_W-1:0] sr_q;

  // the start bit (1) walks down from the MSB; arriving at bit 0 marks a full frame
  always_ff @(posedge clk) begin
    if (rst || flush_i || done_o) sr_q <= '0;
    else if (fall_i && armed_i)   sr_q <= {bit_i, sr_q[FRAME_W-1:1]};
  end

  assign done_o = sr_q[0];
  assign byte_o = sr_q[FRAME_W-1:1];

  assert_frozen_when_inhibited_R5: assert property (@(posedge clk) disable iff (rst)
    (!armed_i && !flush_i && !done_o) |=> $stable(sr_q));
  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (sr_q == '0));
endmodule

// File: rtl/kbd_rx_hold.sv
module kbd_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [BYTE_W-1:0] held_o,
  output logic              irq_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      held_o <= '0;
      irq_o  <= 1'b0;
    end else if (done_i && !irq_o) begin
      held_o <= byte_i;
      irq_o  <= 1'b1;
    end
  end

  assert_irq_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clear_i) |=> irq_o);
  assert_clear_drops_irq_R7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !irq_o);
  assert_byte_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !clear_i) |=> $stable(held_o));
endmodule

// File: rtl/kbd_serial_rx.sv
module kbd_serial_rx
  import kbd_rx_pkg::*;
#(
  parameter int BYTE_W      = KBD_BYTE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_clk_i,
  input  logic              kbd_data_i,
  input  logic              ctl_enable_i,
  input  logic              ctl_clear_i,
  output logic              kbd_clk_hold_o,
  output logic [BYTE_W-1:0] port_a_o,
  output logic              irq_o
);
  kbd_ctl_t    ctl;
  logic        clk_s, data_s, clk_prev_q, fall;
  logic        armed, done;
  logic [BYTE_W-1:0] frame_byte, held_byte;

  assign ctl.clear  = ctl_clear_i;
  assign ctl.enable = ctl_enable_i;

  kbd_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_clk (
    .clk(clk), .rst(rst), .async_i(kbd_clk_i), .sync_o(clk_s));
  kbd_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_data (
    .clk(clk), .rst(rst), .async_i(kbd_data_i), .sync_o(data_s));

  always_ff @(posedge clk) begin
    if (rst) clk_prev_q <= 1'b1;
    else     clk_prev_q <= clk_s;
  end

  assign fall  = clk_prev_q && !clk_s;
  assign armed = ctl.enable && !ctl.clear && !irq_o;

  kbd_rx_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk(clk), .rst(rst), .flush_i(ctl.clear), .armed_i(armed),
    .fall_i(fall), .bit_i(data_s), .done_o(done), .byte_o(frame_byte));

  kbd_rx_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst(rst), .clear_i(ctl.clear), .done_i(done),
    .byte_i(frame_byte), .held_o(held_byte), .irq_o(irq_o));

  assign port_a_o       = ctl.clear ? '0 : held_byte;
  assign kbd_clk_hold_o = !armed;

  assert_erased_after_clear_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_clear_i) |-> (port_a_o == '0));
  assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && port_a_o == '0));
endmodule

// File: tb/kbd_serial_rx_tb_top.sv
module kbd_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kclk = 1'b1, kdat = 1'b1, en = 1'b0, clr = 1'b0;
  logic       hold, irq;
  logic [7:0] pa;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  kbd_serial_rx dut_i (
    .clk(clk), .rst(rst), .kbd_clk_i(kclk), .kbd_data_i(kdat),
    .ctl_enable_i(en), .ctl_clear_i(clr), .kbd_clk_hold_o(hold),
    .port_a_o(pa), .irq_o(irq));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); kdat = b;
    idle(6); kclk = 1'b0;
    idle(6); kclk = 1'b1;
    idle(6);
  endtask

  task automatic send_frame(input logic [7:0] v);
    send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clr = 1'b1;
    idle(1);
    check("R4 port blank during clear", pa, 8'h00);
    check("R8 hold during clear", {7'b0, hold}, 8'h01);
    idle(2); clr = 1'b0;
    idle(1);
    check("R7 irq dropped", {7'b0, irq}, 8'h00);
    check("R4 byte erased", pa, 8'h00);
  endtask

  task automatic t_reset();
    idle(3); rst = 1'b0; idle(2);
    check("R9 irq after reset", {7'b0, irq}, 8'h00);
    check("R9 port after reset", pa, 8'h00);
    check("R8 hold while disabled", {7'b0, hold}, 8'h01);
    en = 1'b1; idle(1);
    check("R8 released when armed", {7'b0, hold}, 8'h00);
  endtask

  task automatic t_byte(input logic [7:0] v);
    send_frame(v);
    check("R2 irq after frame", {7'b0, irq}, 8'h01);
    check("R1 R3 byte on port", pa, v);
    check("R8 hold while pending", {7'b0, hold}, 8'h01);
    pulse_clear();
  endtask

  task automatic t_locked();
    send_frame(8'hA5);
    send_frame(8'h12);
    check("R6 byte kept while pending", pa, 8'hA5);
    check("R2 irq still high", {7'b0, irq}, 8'h01);
    pulse_clear();
    check("R7 re-armed", {7'b0, hold}, 8'h00);
  endtask

  task automatic t_inhibit();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);   // start, d0=0, d1=1
    en = 1'b0; idle(2);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    check("R5 no irq while inhibited", {7'b0, irq}, 8'h00);
    en = 1'b1; idle(2);
    for (int i = 2; i < 8; i++) send_bit(1'b0);        // d2..d7 = 0
    check("R5 partial frame frozen", pa, 8'h02);
    pulse_clear();
  endtask

  task automatic t_clear_partial();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    pulse_clear();
    send_frame(8'h5A);
    check("R7 partial frame discarded", pa, 8'h5A);
    pulse_clear();
  endtask

  task automatic t_reset_partial();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    @(negedge clk); rst = 1'b1; idle(2); rst = 1'b0; idle(2);
    check("R9 reset mid-frame irq", {7'b0, irq}, 8'h00);
    send_frame(8'hC3);
    check("R9 frame after reset", pa, 8'hC3);
    pulse_clear();
  endtask

  initial begin
    t_reset();
    t_byte(8'hA5);
    t_byte(8'h00);
    t_byte(8'hFF);
    t_byte(8'h3C);
    t_locked();
    t_inhibit();
    t_clear_partial();
    t_reset_partial();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule